// File: doc/BRIEF.md
# Multi-Colour Pixel Compare Unit

This block tests the eight pixels stored at one byte address of a three-plane (blue, red, green) frame buffer against a table of eight reference colours. Each pixel's colour is built from one bit per plane. Every pixel whose colour equals at least one valid reference entry sets its bit in an 8-bit match status byte, which the host reads back.

The host loads the reference table through a write port. Each entry carries its own invalid flag, and all entries start out invalid. A plane-disable register removes planes from the comparison: a disabled plane's bit is cleared in both the reference colours and the pixel colours before they are matched. The host then pulses `start` with a byte address. The unit fetches the three plane bytes over a read port that returns data one cycle later. It evaluates all eight pixels in parallel and updates the status byte together with a one-cycle `done` pulse.

Top module: `pixcmp_unit`

## Requirements
- R1: After a synchronous reset, `status` is 0x00, `done` is low and no read is issued. Every reference entry is invalid, so a compare run before any entry is written returns 0x00.
- R2: A cycle with `ref_we` high writes `ref_wdata` into the entry chosen by `ref_idx`. An entry whose bit 7 is 1 takes no part in matching.
- R3: Only bits 2..0 of an entry are colour. Bits 6..3 have no effect on the result.
- R4: Plane 0 is blue, plane 1 is red and plane 2 is green. A pixel's colour is its green bit in colour bit 2, its red bit in colour bit 1 and its blue bit in colour bit 0.
- R5: Status bit k belongs to the pixel held in data bit k, so bit 7 is the leftmost pixel. The bit is 1 when the pixel's masked colour equals the masked colour of any valid entry.
- R6: A 1 in bit n of the disable register (written with `dis_we`) removes plane n from both sides of the comparison. With all three planes disabled, every pixel matches as long as at least one entry is valid.
- R7: A start accepted while idle issues `mem_rd_en` on three consecutive cycles, reading planes 0, 1 and 2 in that order at `start_addr`. Read data is expected on `mem_rd_data` one cycle after each request.
- R8: In the cycle after an accepted start, `status` is 0x00. On the 4th rising edge after the edge that accepts the start, `status` takes the new result and `done` is high for exactly one cycle. At all other times `status` holds its value.
- R9: A `start` pulse that arrives while a compare is running is ignored. It produces no extra reads, no extra `done` and no change of address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_we | input | 1 | Reference entry write enable |
| ref_idx | input | 3 | Reference entry index |
| ref_wdata | input | 8 | Entry value: bit 7 invalid flag, bits 2..0 colour |
| dis_we | input | 1 | Plane-disable register write enable |
| dis_wdata | input | 3 | Plane-disable bits, bit n for plane n |
| start | input | 1 | Start a compare (ignored while busy) |
| start_addr | input | 14 | Byte address to compare |
| mem_rd_en | output | 1 | Plane read request |
| mem_rd_plane | output | 2 | Plane being read (0 blue, 1 red, 2 green) |
| mem_rd_addr | output | 14 | Read address |
| mem_rd_data | input | 8 | Plane byte, valid one cycle after the request |
| status | output | 8 | Match status, bit k for pixel k |
| done | output | 1 | One-cycle pulse when status is updated |

## Verification
The test byte holds all eight colours, one per pixel position. A single matching entry therefore shows at once whether the plane-to-colour-bit mapping and the status bit positions are right, and a second valid entry shows that matches combine with OR. Changing an entry to invalid, and filling its unused middle bits, separates the validity flag from the colour field. Disable patterns of one plane and of all planes check the masking on both sides of the comparison. A second start issued mid-run, on a byte with the colours in inverted positions, would change both the result and the read address if it were wrongly accepted.

// File: rtl/pixcmp_pkg.sv
package pixcmp_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/pixcmp_reftable.sv
module pixcmp_reftable #(
  parameter int NREF   = 8,
  parameter int NPLANE = 3,
  parameter int REF_W  = 8,
  localparam int IW    = $clog2(NREF)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ref_we,
  input  logic [IW-1:0]            ref_idx,
  input  logic [REF_W-1:0]         ref_wdata,
  input  logic                     dis_we,
  input  logic [NPLANE-1:0]        dis_wdata,
  output logic [NREF-1:0]          ref_ok,
  output logic [NREF*NPLANE-1:0]   ref_col,
  output logic [NPLANE-1:0]        cmp_mask
);
  logic [NPLANE-1:0] dis_q;
  logic [NREF-1:0]   inv_q;
  logic [NPLANE-1:0] col_q [NREF];

  always_ff @(posedge clk) begin
    if (rst) dis_q <= '0;
    else if (dis_we) dis_q <= dis_wdata;
  end

  assign cmp_mask = ~dis_q;

  for (genvar e = 0; e < NREF; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        inv_q[e] <= 1'b1;
        col_q[e] <= '0;
      end else if (ref_we && (ref_idx == IW'(e))) begin
        inv_q[e] <= ref_wdata[REF_W-1];
        col_q[e] <= ref_wdata[NPLANE-1:0];
      end
    end
    assign ref_ok[e] = ~inv_q[e];
    assign ref_col[e*NPLANE +: NPLANE] = col_q[e] & cmp_mask;
  end

  if (REF_W - 1 > NPLANE) begin : g_spare
    logic unused_spare_bits;
    assign unused_spare_bits = ^ref_wdata[REF_W-2:NPLANE];
  end
endmodule

// File: rtl/pixcmp_seq.sv
module pixcmp_seq
  import pixcmp_pkg::*;
#(
  parameter int NPLANE = 3,
  parameter int PIX    = 8,
  parameter int AW     = 14,
  localparam int PW    = $clog2(NPLANE),
  localparam int PHW   = $clog2(NPLANE + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [AW-1:0]          start_addr,
  output logic                   mem_rd_en,
  output logic [PW-1:0]          mem_rd_plane,
  output logic [AW-1:0]          mem_rd_addr,
  input  logic [PIX-1:0]         mem_rd_data,
  output logic                   busy,
  output logic                   accept,
  output logic                   eval_now,
  output logic [NPLANE*PIX-1:0]  planes
);
  seq_state_t        state_q;
  logic [PHW-1:0]    ph_q;
  logic [PIX-1:0]    cap_q [NPLANE-1];

  assign busy     = (state_q == SEQ_RUN);
  assign accept   = start && !busy;
  assign eval_now = busy && (int'(ph_q) == NPLANE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SEQ_IDLE;
      ph_q         <= '0;
      mem_rd_en    <= 1'b0;
      mem_rd_plane <= '0;
      mem_rd_addr  <= '0;
    end else if (accept) begin
      state_q      <= SEQ_RUN;
      ph_q         <= '0;
      mem_rd_en    <= 1'b1;
      mem_rd_plane <= '0;
      mem_rd_addr  <= start_addr;
    end else if (busy) begin
      ph_q <= ph_q + 1'b1;
      if (int'(ph_q) + 1 < NPLANE) begin
        mem_rd_en    <= 1'b1;
        mem_rd_plane <= PW'(int'(ph_q) + 1);
      end else begin
        mem_rd_en <= 1'b0;
      end
      if (eval_now) state_q <= SEQ_IDLE;
    end
  end

  for (genvar c = 0; c < NPLANE - 1; c++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) cap_q[c] <= '0;
      else if (busy && (int'(ph_q) == c + 1)) cap_q[c] <= mem_rd_data;
    end
    assign planes[c*PIX +: PIX] = cap_q[c];
  end
  assign planes[(NPLANE-1)*PIX +: PIX] = mem_rd_data;
endmodule

// File: rtl/pixcmp_match.sv
module pixcmp_match #(
  parameter int NREF   = 8,
  parameter int NPLANE = 3,
  parameter int PIX    = 8
) (
  input  logic [NPLANE*PIX-1:0]  planes,
  input  logic [NREF-1:0]        ref_ok,
  input  logic [NREF*NPLANE-1:0] ref_col,
  input  logic [NPLANE-1:0]      cmp_mask,
  output logic [PIX-1:0]         hit
);
  for (genvar p = 0; p < PIX; p++) begin : g_pix
    logic [NPLANE-1:0] pcol;
    for (genvar k = 0; k < NPLANE; k++) begin : g_bit
      assign pcol[k] = planes[k*PIX + p] & cmp_mask[k];
    end
    always_comb begin
      hit[p] = 1'b0;
      for (int e = 0; e < NREF; e++) begin
        if (ref_ok[e] && (ref_col[e*NPLANE +: NPLANE] == pcol)) hit[p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixcmp_unit.sv
module pixcmp_unit #(
  parameter int NREF   = 8,
  parameter int NPLANE = 3,
  parameter int PIX    = 8,
  parameter int REF_W  = 8,
  parameter int AW     = 14,
  localparam int IW    = $clog2(NREF),
  localparam int PW    = $clog2(NPLANE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_we,
  input  logic [IW-1:0]     ref_idx,
  input  logic [REF_W-1:0]  ref_wdata,
  input  logic              dis_we,
  input  logic [NPLANE-1:0] dis_wdata,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  output logic              mem_rd_en,
  output logic [PW-1:0]     mem_rd_plane,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [PIX-1:0]    mem_rd_data,
  output logic [PIX-1:0]    status,
  output logic              done
);
  logic [NREF-1:0]         ref_ok;
  logic [NREF*NPLANE-1:0]  ref_col;
  logic [NPLANE-1:0]       cmp_mask;
  logic                    busy, accept, eval_now;
  logic [NPLANE*PIX-1:0]   planes;
  logic [PIX-1:0]          hit;

  pixcmp_reftable #(.NREF(NREF), .NPLANE(NPLANE), .REF_W(REF_W)) u_tab (
    .clk(clk), .rst(rst), .ref_we(ref_we), .ref_idx(ref_idx), .ref_wdata(ref_wdata),
    .dis_we(dis_we), .dis_wdata(dis_wdata), .ref_ok(ref_ok), .ref_col(ref_col),
    .cmp_mask(cmp_mask));

  pixcmp_seq #(.NPLANE(NPLANE), .PIX(PIX), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_plane(mem_rd_plane), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .busy(busy), .accept(accept), .eval_now(eval_now),
    .planes(planes));

  pixcmp_match #(.NREF(NREF), .NPLANE(NPLANE), .PIX(PIX)) u_match (
    .planes(planes), .ref_ok(ref_ok), .ref_col(ref_col), .cmp_mask(cmp_mask), .hit(hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      done   <= 1'b0;
    end else begin
      done <= eval_now;
      if (accept) status <= '0;
      else if (eval_now) status <= hit;
    end
  end
endmodule

// File: rtl/pixcmp_chk.sv
module pixcmp_chk #(
  parameter int PIX    = 8,
  parameter int PW     = 2,
  parameter int AW     = 14,
  parameter int NPLANE = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [PIX-1:0] status,
  input logic           mem_rd_en,
  input logic [PW-1:0]  mem_rd_plane,
  input logic [AW-1:0]  mem_rd_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (status == '0) && !done && !mem_rd_en); // R1
  AST_RD_ORDER: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && (int'(mem_rd_plane) < NPLANE - 1)) |=>
      (mem_rd_en && (mem_rd_plane == PW'(int'($past(mem_rd_plane)) + 1)))); // R7
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (status == '0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> (done || busy)); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mem_rd_addr)); // R9
endmodule

bind pixcmp_unit pixcmp_chk #(.PIX(PIX), .PW(PW), .AW(AW), .NPLANE(NPLANE)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .status(status),
  .mem_rd_en(mem_rd_en), .mem_rd_plane(mem_rd_plane), .mem_rd_addr(mem_rd_addr));

// File: tb/pixcmp_unit_bench.sv
`timescale 1ns/1ps
module pixcmp_unit_bench;
  localparam int AW = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_we = 1'b0, dis_we = 1'b0, start = 1'b0;
  logic [2:0] ref_idx = '0, dis_wdata = '0;
  logic [7:0] ref_wdata = '0;
  logic [AW-1:0] start_addr = '0;
  logic mem_rd_en, done;
  logic [1:0] mem_rd_plane;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0] mem_rd_data = '0, status;

  int total = 0, fails = 0;
  logic [7:0] mem [0:2][0:15];

  always #2 clk = ~clk;

  pixcmp_unit #(.AW(AW)) u_pixcmp_unit (
    .clk(clk), .rst(rst), .ref_we(ref_we), .ref_idx(ref_idx), .ref_wdata(ref_wdata),
    .dis_we(dis_we), .dis_wdata(dis_wdata), .start(start), .start_addr(start_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_plane(mem_rd_plane), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .status(status), .done(done));

  // Frame buffer with one-cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_plane][mem_rd_addr];

  // Read and done monitors
  int rd_cnt = 0, done_cnt = 0, plane_log = 0, bad_addr = 0;
  logic [AW-1:0] exp_addr = '0;
  always @(posedge clk) begin
    if (!rst && mem_rd_en) begin
      rd_cnt <= rd_cnt + 1;
      plane_log <= plane_log * 4 + int'(mem_rd_plane);
      if (mem_rd_addr != exp_addr) bad_addr <= bad_addr + 1;
    end
    if (!rst && done) done_cnt <= done_cnt + 1;
  end

  // Behavioural reference model
  logic [7:0] m_ref [0:7];
  logic [2:0] m_dis;
  logic [7:0] m_status;
  logic m_done, m_busy;
  int m_cnt;
  logic [AW-1:0] m_addr;

  function automatic logic [7:0] model_cmp(input logic [AW-1:0] a);
    logic [7:0] r = 8'h00;
    logic [2:0] mk = ~m_dis;
    for (int p = 0; p < 8; p++) begin
      logic [2:0] col = {mem[2][a][p], mem[1][a][p], mem[0][a][p]} & mk;
      for (int j = 0; j < 8; j++)
        if (!m_ref[j][7] && ((m_ref[j][2:0] & mk) == col)) r[p] = 1'b1;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_status = 0; m_done = 0; m_dis = 0; m_addr = 0;
      for (int j = 0; j < 8; j++) m_ref[j] = 8'h80;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 4) begin
          m_status = model_cmp(m_addr); m_done = 1; m_busy = 0;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_status = 0; m_addr = start_addr;
      end
      if (ref_we) m_ref[ref_idx] = ref_wdata;
      if (dis_we) m_dis = dis_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(status == m_status, "R5 per-cycle status", status, m_status);
      check(done == m_done, "R8 per-cycle done", done, m_done);
    end
  end

  task automatic wr_ref(input int idx, input logic [7:0] v);
    @(negedge clk); ref_we = 1; ref_idx = 3'(idx); ref_wdata = v;
    @(negedge clk); ref_we = 0;
  endtask

  task automatic wr_dis(input logic [2:0] v);
    @(negedge clk); dis_we = 1; dis_wdata = v;
    @(negedge clk); dis_we = 0;
  endtask

  task automatic run(input logic [AW-1:0] a, input logic [7:0] exp, input string tag, input bit again);
    int n = 1;
    int d0 = done_cnt;
    @(negedge clk);
    rd_cnt = 0; plane_log = 0; bad_addr = 0; exp_addr = a;
    start = 1; start_addr = a;
    @(negedge clk); start = 0;
    check(status == 8'h00, "R8 clear after start", status, 0);
    if (again) begin
      @(negedge clk); n++;
      start = 1; start_addr = a ^ 4'hA;
      @(negedge clk); n++; start = 0;
    end
    while (!done && n < 20) begin @(negedge clk); n++; end
    check(n == 5, "R8 done latency", n, 5);
    check(status == exp, tag, status, exp);
    @(negedge clk);
    check(rd_cnt == 3, "R7 read count", rd_cnt, 3);
    check(plane_log == 6, "R7 plane order", plane_log, 6);
    check(bad_addr == 0, "R7 read address", bad_addr, 0);
    check(done_cnt - d0 == 1, "R9 one done per run", done_cnt - d0, 1);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) begin
      mem[0][a] = 8'h00; mem[1][a] = 8'h00; mem[2][a] = 8'h00;
    end
    mem[0][3] = 8'hF0; mem[1][3] = 8'hCC; mem[2][3] = 8'hAA; // colours 7,3,5,1,6,2,4,0
    mem[0][9] = 8'h0F; mem[1][9] = 8'h33; mem[2][9] = 8'h55; // colours 0,4,2,6,1,5,3,7
    repeat (3) @(negedge clk);
    check(status == 8'h00 && !done && !mem_rd_en, "R1 reset state", {done, mem_rd_en, status}, 0);
    rst = 0;
    run(4'd3, 8'h00, "R1 entries invalid after reset", 0);
    wr_ref(0, 8'h05);
    run(4'd3, 8'h20, "R4 colour bit mapping", 0);
    wr_ref(1, 8'h03);
    run(4'd3, 8'h60, "R5 any valid entry matches", 0);
    wr_ref(1, 8'h83);
    run(4'd3, 8'h20, "R2 invalid flag excludes entry", 0);
    wr_ref(0, 8'h7D);
    run(4'd3, 8'h20, "R3 middle bits ignored", 0);
    wr_dis(3'b001);
    run(4'd3, 8'h22, "R6 blue plane disabled", 0);
    wr_dis(3'b111);
    run(4'd3, 8'hFF, "R6 all planes disabled", 0);
    wr_ref(0, 8'h80);
    run(4'd3, 8'h00, "R6 all disabled no valid entry", 0);
    wr_dis(3'b000);
    wr_ref(0, 8'h05);
    run(4'd9, 8'h04, "R9 start while busy ignored", 1);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule